// File: doc/BRIEF.md
# Single-Precision Operand Exception Detector

This block examines the opcode and the two 32-bit single-precision operands of a floating-point operation and decides the exceptions that follow from the operands alone. It does this while the datapath is still computing. It reports four flags: invalid operation, division by zero, subnormal operand and integer-out-of-range for conversions. Overflow, underflow and inexact depend on the rounded result, so the arithmetic pipeline detects those and this block does not.

A caller presents an opcode, the operands and the subnormals-as-zero mode bit with a one-cycle `in_valid` strobe. The flags for that operation appear on the next cycle with `out_valid`. Each operand is first classified as zero, subnormal, infinite, quiet NaN or signalling NaN. A rule stage then combines the classes according to the opcode. With the mode bit set, a subnormal operand counts as zero in every rule.

Top module: `fp_opexc_detect`

## Requirements
- R1: Outputs are registered. `out_valid` equals `in_valid` of the previous cycle. All four flags are 0 whenever `out_valid` is 0, and all outputs are 0 during reset (`rst_n` low, asynchronous). Opcodes are 0 add, 1 subtract, 2 multiply, 3 divide, 4 square root, 5 convert to signed 32-bit integer and 6 convert to signed 64-bit integer.
- R2: A signalling NaN sets invalid. Such a value has exponent field all ones, fraction nonzero and fraction bit 22 equal to 0. This applies to any operand the opcode uses. A quiet NaN (fraction bit 22 set) sets no flag by itself.
- R3: Add of two infinities with different signs sets invalid. Subtract of two infinities with equal signs sets invalid.
- R4: Multiply of zero by infinity, in either order, sets invalid. Divide of zero by zero sets invalid, and so does infinity by infinity.
- R5: Square root of a negative operand that is neither zero nor a NaN sets invalid. Negative zero does not.
- R6: Divide-by-zero is set only for opcode 3, when the dividend is finite, nonzero and not a NaN and the divisor is zero.
- R7: For opcodes 5 and 6, integer-out-of-range is set when the operand, truncated toward zero, lies outside the signed 32-bit or 64-bit range. Infinities count as out of range. The exact value -2^31 (or -2^63) does not.
- R8: Subnormal-operand is set when a used operand has exponent field 0 and a nonzero fraction while the mode bit is 0.
- R9: With the mode bit at 1, subnormal operands count as zero for R4, R5 and R6, and R8 never fires.
- R10: For square root and both conversions, operand `in_b` has no effect on any flag.
- R11: Opcode 7 is reserved and produces no flags.
- R12: A NaN of either kind given to a conversion sets invalid and never integer-out-of-range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Opcode |
| in_a | input | 32 | First operand (dividend, radicand, conversion source) |
| in_b | input | 32 | Second operand |
| saz_mode | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Flags valid |
| out_invalid | output | 1 | Invalid-operation flag |
| out_div0 | output | 1 | Divide-by-zero flag |
| out_subop | output | 1 | Subnormal-operand flag |
| out_hugeint | output | 1 | Integer-out-of-range flag |

## Verification
The hardest cases to reach are where classes interact. Examples are a negative subnormal radicand, or a subnormal divisor under the zero-treating mode, and a conversion input lying exactly at or one step beyond the negative integer limit. Random values rarely reach these. The stimulus therefore takes every pairing from a fixed set of 16 hand-picked encodings, under all eight opcodes and both mode settings. That set covers signed zeros, subnormals of both signs, infinities, both NaN kinds and the powers of two on each side of the integer limits.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_DIV   = 3'd3,
        OP_SQRT  = 3'd4,
        OP_CVT32 = 3'd5,
        OP_CVT64 = 3'd6,
        OP_RSVD  = 3'd7
    } fp_op_e;

    typedef struct packed {
        logic             neg;
        logic             zero;      // zero, or subnormal flushed by mode
        logic             subn;      // raw subnormal encoding
        logic             inf;
        logic             nan;
        logic             snan;
        logic             frac_zero;
        logic [EXP_W-1:0] exp;
    } fp_class_t;

    typedef struct packed {
        logic invalid;
        logic div0;
        logic subop;
        logic hugeint;
    } fp_flags_t;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
    import fpx_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              flush_i,
    output fp_class_t         cls_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_nz;

    always_comb begin
        exp_f    = word_i[WORD_W-2 -: EXP_W];
        frac_f   = word_i[FRAC_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        frac_nz  = |frac_f;

        cls_o.neg       = word_i[WORD_W-1];
        cls_o.subn      = exp_zero & frac_nz;
        cls_o.zero      = exp_zero & (~frac_nz | flush_i);
        cls_o.inf       = exp_ones & ~frac_nz;
        cls_o.nan       = exp_ones & frac_nz;
        cls_o.snan      = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
        cls_o.frac_zero = ~frac_nz;
        cls_o.exp       = exp_f;
    end
endmodule

// File: rtl/fpx_range.sv
module fpx_range
    import fpx_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  fp_class_t cls_i,
    output logic      huge_o
);
    // exponent field value of 2^(INT_W-1)
    localparam int LIMIT = BIAS + INT_W - 1;

    logic above;
    logic at_edge;

    always_comb begin
        above   = int'(cls_i.exp) > LIMIT;
        at_edge = int'(cls_i.exp) == LIMIT;
        // exact negative power of two at the edge still fits
        huge_o  = ~cls_i.nan & (above | (at_edge & ~(cls_i.neg & cls_i.frac_zero)));
    end
endmodule

// File: rtl/fpx_rules.sv
module fpx_rules
    import fpx_pkg::*;
(
    input  fp_op_e    op_i,
    input  fp_class_t ca_i,
    input  fp_class_t cb_i,
    input  logic      flush_i,
    input  logic      huge_narrow_i,
    input  logic      huge_wide_i,
    output fp_flags_t flags_o
);
    logic two_op;
    logic snan_seen;
    logic subn_seen;
    logic same_sign;

    always_comb begin
        two_op    = (op_i == OP_ADD) | (op_i == OP_SUB) | (op_i == OP_MUL) | (op_i == OP_DIV);
        snan_seen = ca_i.snan | (two_op & cb_i.snan);
        subn_seen = ~flush_i & (ca_i.subn | (two_op & cb_i.subn));
        same_sign = ~(ca_i.neg ^ cb_i.neg);

        flags_o         = '0;
        flags_o.invalid = snan_seen;
        flags_o.subop   = subn_seen;

        unique case (op_i)
            OP_ADD: flags_o.invalid = snan_seen | (ca_i.inf & cb_i.inf & ~same_sign);
            OP_SUB: flags_o.invalid = snan_seen | (ca_i.inf & cb_i.inf & same_sign);
            OP_MUL: flags_o.invalid = snan_seen | (ca_i.zero & cb_i.inf) | (ca_i.inf & cb_i.zero);
            OP_DIV: begin
                flags_o.invalid = snan_seen | (ca_i.zero & cb_i.zero) | (ca_i.inf & cb_i.inf);
                flags_o.div0    = cb_i.zero & ~ca_i.zero & ~ca_i.inf & ~ca_i.nan;
            end
            OP_SQRT: flags_o.invalid = snan_seen | (ca_i.neg & ~ca_i.zero & ~ca_i.nan);
            OP_CVT32: begin
                flags_o.invalid = ca_i.nan;
                flags_o.hugeint = huge_narrow_i;
            end
            OP_CVT64: begin
                flags_o.invalid = ca_i.nan;
                flags_o.hugeint = huge_wide_i;
            end
            default: flags_o = '0;
        endcase
    end
endmodule

// File: rtl/fp_opexc_detect.sv
module fp_opexc_detect
    import fpx_pkg::*;
#(
    parameter int NARROW_W = 32,
    parameter int WIDE_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic              saz_mode,
    output logic              out_valid,
    output logic              out_invalid,
    output logic              out_div0,
    output logic              out_subop,
    output logic              out_hugeint
);
    localparam int N_OPND = 2;

    typedef struct packed {
        logic      valid;
        fp_flags_t flags;
    } stage_t;

    logic [WORD_W-1:0] opnd   [N_OPND];
    fp_class_t         cls    [N_OPND];
    logic              huge_n;
    logic              huge_w;
    fp_flags_t         rule_flags;
    stage_t            st_d;
    stage_t            st_q;

    assign opnd[0] = in_a;
    assign opnd[1] = in_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        fpx_classify u_cls (
            .word_i (opnd[g]),
            .flush_i(saz_mode),
            .cls_o  (cls[g])
        );
    end

    fpx_range #(.INT_W(NARROW_W)) u_rng_n (.cls_i(cls[0]), .huge_o(huge_n));
    fpx_range #(.INT_W(WIDE_W))   u_rng_w (.cls_i(cls[0]), .huge_o(huge_w));

    fpx_rules u_rules (
        .op_i         (fp_op_e'(in_op)),
        .ca_i         (cls[0]),
        .cb_i         (cls[1]),
        .flush_i      (saz_mode),
        .huge_narrow_i(huge_n),
        .huge_wide_i  (huge_w),
        .flags_o      (rule_flags)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.flags = in_valid ? rule_flags : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_invalid = st_q.flags.invalid;
    assign out_div0    = st_q.flags.div0;
    assign out_subop   = st_q.flags.subop;
    assign out_hugeint = st_q.flags.hugeint;
endmodule

// File: rtl/fpx_checker.sv
module fpx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  in_op,
    input logic        saz_mode,
    input logic        out_valid,
    input logic        out_invalid,
    input logic        out_div0,
    input logic        out_subop,
    input logic        out_hugeint
);
    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_invalid || out_div0 || out_subop || out_hugeint));

    // R6
    div0_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_div0 |-> $past(in_op) == 3'd3);

    // R7
    huge_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hugeint |-> ($past(in_op) == 3'd5 || $past(in_op) == 3'd6));

    // R9
    subop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_subop |-> !$past(saz_mode));

    // R12
    huge_not_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_hugeint, out_invalid}) || !out_hugeint);

    // R11
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_op) == 3'd7 |-> !(out_invalid || out_div0 || out_subop || out_hugeint));
endmodule

bind fp_opexc_detect fpx_checker u_chk (.*);

// File: tb/sim_fp_opexc_detect.sv
module sim_fp_opexc_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        saz_mode = 1'b0;
    logic        out_valid, out_invalid, out_div0, out_subop, out_hugeint;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fp_opexc_detect u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .saz_mode(saz_mode),
        .out_valid(out_valid), .out_invalid(out_invalid), .out_div0(out_div0),
        .out_subop(out_subop), .out_hugeint(out_hugeint)
    );

    function automatic logic [31:0] pick(input int i);
        case (i)
            0:  return 32'h0000_0000;  // +0
            1:  return 32'h8000_0000;  // -0
            2:  return 32'h0000_0001;  // +subnormal
            3:  return 32'h8040_0000;  // -subnormal
            4:  return 32'h3F80_0000;  // +1
            5:  return 32'hBF80_0000;  // -1
            6:  return 32'h7F80_0000;  // +inf
            7:  return 32'hFF80_0000;  // -inf
            8:  return 32'h7FC0_0000;  // quiet NaN
            9:  return 32'h7F80_0001;  // signalling NaN
            10: return 32'hFFA0_0000;  // -signalling NaN
            11: return 32'h4F00_0000;  // 2^31
            12: return 32'hCF00_0000;  // -2^31
            13: return 32'hCF00_0001;  // just below -2^31
            14: return 32'h5F00_0000;  // 2^63
            default: return 32'hDF00_0000; // -2^63
        endcase
    endfunction

    // expected {invalid, div0, subop, hugeint}
    function automatic logic [3:0] expect_flags(input int op, input logic [31:0] a,
                                                input logic [31:0] b, input logic saz);
        int  ea = int'(a[30:23]);
        int  eb = int'(b[30:23]);
        bit  sa = a[31], sb = b[31];
        bit  a_nan = (ea == 255) && (a[22:0] != 0);
        bit  b_nan = (eb == 255) && (b[22:0] != 0);
        bit  a_sn = a_nan && !a[22];
        bit  b_sn = b_nan && !b[22];
        bit  a_inf = (ea == 255) && (a[22:0] == 0);
        bit  b_inf = (eb == 255) && (b[22:0] == 0);
        bit  a_den = (ea == 0) && (a[22:0] != 0);
        bit  b_den = (eb == 0) && (b[22:0] != 0);
        bit  a_z = (ea == 0) && (a[22:0] == 0 || saz);
        bit  b_z = (eb == 0) && (b[22:0] == 0 || saz);
        bit  inv = 0, dz = 0, sub = 0, hg = 0;
        int  unb = ea - 127;
        int  lim;
        if (op <= 3) begin
            inv = a_sn || b_sn;
            sub = !saz && (a_den || b_den);
        end else if (op <= 6) begin
            inv = a_sn;
            sub = !saz && a_den;
        end
        case (op)
            0: if (a_inf && b_inf && sa != sb) inv = 1;
            1: if (a_inf && b_inf && sa == sb) inv = 1;
            2: if ((a_z && b_inf) || (a_inf && b_z)) inv = 1;
            3: begin
                if ((a_z && b_z) || (a_inf && b_inf)) inv = 1;
                dz = b_z && !a_z && !a_inf && !a_nan;
            end
            4: if (sa && !a_z && !a_nan) inv = 1;
            5, 6: begin
                lim = (op == 5) ? 31 : 63;
                inv = a_nan;
                hg  = !a_nan && (unb > lim || (unb == lim && !(sa && a[22:0] == 0)));
            end
            default: ;
        endcase
        return {inv, dz, sub, hg};
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h saz=%0b actual=%0b expected=%0b",
                     tag, in_op, in_a, in_b, saz_mode, act, exp);
        end
    endtask

    function automatic string inv_tag(input int op);
        case (op)
            0, 1: return "R3";
            2, 3: return "R4";
            4:    return "R5";
            5, 6: return "R12";
            default: return "R11";
        endcase
    endfunction

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        logic [3:0] e;
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 reset valid", out_valid, 1'b0);
        check("R1 reset flags", |{out_invalid, out_div0, out_subop, out_hugeint}, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: R2 signalling NaN, R8/R9 mode, R10 b ignored for op 4..6
        for (int s = 0; s < 2; s++) begin
            for (int op = 0; op < 8; op++) begin
                for (int i = 0; i < 16; i++) begin
                    for (int j = 0; j < 16; j++) begin
                        in_valid = 1'b1;
                        in_op    = 3'(op);
                        in_a     = pick(i);
                        in_b     = pick(j);
                        saz_mode = s[0];
                        e = expect_flags(op, pick(i), pick(j), s[0]);
                        @(negedge clk);
                        check("R1 valid", out_valid, 1'b1);
                        check(inv_tag(op), out_invalid, e[3]);
                        check("R6 div0", out_div0, e[2]);
                        check(s[0] ? "R9 subop" : "R8 subop", out_subop, e[1]);
                        check("R7 huge", out_hugeint, e[0]);
                    end
                end
            end
        end

        // R1: no strobe means no flags even for a flag-raising input
        in_valid = 1'b0;
        in_op    = 3'd3;
        in_a     = 32'h7F80_0001;
        in_b     = 32'h0000_0000;
        saz_mode = 1'b0;
        @(negedge clk);
        check("R1 idle valid", out_valid, 1'b0);
        check("R1 idle flags", |{out_invalid, out_div0, out_subop, out_hugeint}, 1'b0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule